// File: doc/BRIEF.md
# Milling Machine Supervisory Controller

This block is a four-state Moore controller that oversees an automatic milling station. It steps the station between an initial setup phase, a component loading phase and a machining phase, using an operator key and a flag that reports a fixed (clamped) condition. A limit switch acts as a global safety override: whenever it reads active, the controller falls into a fault state that raises an alarm and stays there until the next reset.

All inputs must already be synchronous to `clk`. The outputs depend only on the registered state. The 2-bit state code is brought out so that surrounding logic can see which phase the station is in. Motor drive, the machining sequence itself and input debouncing belong to other blocks.

Top module: `mill_supervisor`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the state becomes setup (code 00) and `alarm` becomes 0, whatever the other inputs are, including `limit_hit` = 1.
- R2: With `rst_n` high, `limit_hit` = 1 at a rising edge makes the next state fault (code 11) from any state. This condition takes priority over every other transition.
- R3: `alarm` is 1 exactly when the state code is 11 (fault), and 0 in every other state.
- R4: Once in fault, no input combination moves the state elsewhere. Only R1 leaves it.
- R5: From loading (code 01) with `limit_hit` = 0, the state moves to machining (code 10) when `key_on` = 1, and stays in loading otherwise.
- R6: From machining (code 10) with `limit_hit` = 0, the state moves to loading (code 01) when `fixed_ok` = 1, and stays in machining otherwise.
- R7: From setup (code 00), the state moves to loading only when `limit_hit` = 0, `key_on` = 0 and `fixed_ok` = 1.
- R8: Any input combination that meets none of the transitions above leaves the state unchanged.
- R9: `state_code` shows the state as setup = 00, loading = 01, machining = 10, fault = 11, and it changes only at rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes occur on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| limit_hit | input | 1 | Limit switch tripped (1 = tripped) |
| key_on | input | 1 | Operator key pressed (1 = pressed) |
| fixed_ok | input | 1 | Fixed condition reached (1 = reached) |
| alarm | output | 1 | Alarm, 1 only in fault |
| state_code | output | 2 | Current state encoding |

## Verification
A wrong next-state decision shows up on `state_code` one clock edge after the input pattern that caused it. A stuck or misdecoded fault shows on `alarm` in that same cycle. Because the fault state absorbs every input, a missed trip or a false exit from fault leaves a divergence that lasts until the next reset. That makes such an error easy to catch, and the bench compares both outputs after every edge against a reference next-state function. A priority mistake, such as the key winning over the limit switch, is visible only in the cycles where both inputs are active together. Such combinations are therefore both targeted by directed cases and mixed into the random stream.

// File: rtl/mill_sup_pkg.sv
// Shared definitions for the milling supervisor.
// Assumes a fixed 2-bit binary encoding that external logic decodes.
package mill_sup_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_SETUP = 2'b00,
        ST_LOAD  = 2'b01,
        ST_RUN   = 2'b10,
        ST_FAULT = 2'b11
    } mill_state_e;
endpackage

// File: rtl/mill_next_state.sv
// Next-state function of the supervisor.
// Assumes synchronous inputs; the limit switch outranks all other conditions.
module mill_next_state
    import mill_sup_pkg::*;
(
    input  mill_state_e cur_state,
    input  logic        limit_hit,
    input  logic        key_on,
    input  logic        fixed_ok,
    output mill_state_e nxt_state
);
    // Pick the following state: limit first, then the per-state rule, else hold.
    always_comb begin
        nxt_state = cur_state;
        if (limit_hit) begin
            nxt_state = ST_FAULT;
        end else begin
            unique case (cur_state)
                ST_SETUP: if (!key_on && fixed_ok) nxt_state = ST_LOAD;
                ST_LOAD:  if (key_on)              nxt_state = ST_RUN;
                ST_RUN:   if (fixed_ok)            nxt_state = ST_LOAD;
                ST_FAULT: nxt_state = ST_FAULT;
                default:  nxt_state = ST_SETUP;
            endcase
        end
    end
endmodule

// File: rtl/mill_state_reg.sv
// State register with synchronous active-low reset.
// Assumes reset outranks any next-state request in the same cycle.
module mill_state_reg
    import mill_sup_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  mill_state_e nxt_state,
    output mill_state_e cur_state
);
    // Capture the next state, or return to setup under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_state <= ST_SETUP;
        else        cur_state <= nxt_state;
    end
endmodule

// File: rtl/mill_alarm_decode.sv
// Moore output decode: the alarm is a function of the state alone.
// Assumes the state comes straight from a register, so the alarm is glitch-free per cycle.
module mill_alarm_decode
    import mill_sup_pkg::*;
(
    input  mill_state_e cur_state,
    output logic        alarm
);
    // Raise the alarm only in fault.
    always_comb begin
        alarm = (cur_state == ST_FAULT);
    end
endmodule

// File: rtl/mill_supervisor.sv
// Top of the milling supervisor: next-state logic, state register, output decode.
// Assumes all inputs are synchronous to clk and already debounced.
module mill_supervisor
    import mill_sup_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               limit_hit,
    input  logic               key_on,
    input  logic               fixed_ok,
    output logic               alarm,
    output logic [STATE_W-1:0] state_code
);
    mill_state_e cur_state;
    mill_state_e nxt_state;

    mill_next_state u_next (
        .cur_state (cur_state),
        .limit_hit (limit_hit),
        .key_on    (key_on),
        .fixed_ok  (fixed_ok),
        .nxt_state (nxt_state)
    );

    mill_state_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    mill_alarm_decode u_dec (
        .cur_state (cur_state),
        .alarm     (alarm)
    );

    // Expose the state encoding for external observers.
    always_comb begin
        state_code = cur_state;
    end
endmodule

// File: rtl/mill_supervisor_chk.sv
// Port-level property checker for the milling supervisor, bound to the top.
module mill_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       limit_hit,
    input logic       key_on,
    input logic       fixed_ok,
    input logic       alarm,
    input logic [1:0] state_code
);
    // R1
    reset_to_setup_chk: assert property (@(posedge clk)
        !rst_n |=> (state_code == 2'b00 && !alarm));

    // R2
    limit_forces_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        limit_hit |=> state_code == 2'b11);

    // R3
    alarm_matches_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm == (state_code == 2'b11));

    // R4
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == 2'b11 |=> state_code == 2'b11);

    // R5
    load_waits_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b01 && !limit_hit && !key_on) |=> state_code == 2'b01);

    // R6
    run_returns_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b10 && !limit_hit && fixed_ok) |=> state_code == 2'b01);

    // R7
    setup_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b00 && !limit_hit && (key_on || !fixed_ok)) |=> state_code == 2'b00);
endmodule

bind mill_supervisor mill_supervisor_chk i_chk (.*);

// File: tb/test_mill_supervisor.sv
module test_mill_supervisor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       limit_hit = 1'b0;
    logic       key_on = 1'b0;
    logic       fixed_ok = 1'b0;
    logic       alarm;
    logic [1:0] state_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [1:0] exp_st = 2'b00;

    always #5 clk = ~clk;

    mill_supervisor i_mill_supervisor (
        .clk(clk), .rst_n(rst_n), .limit_hit(limit_hit), .key_on(key_on),
        .fixed_ok(fixed_ok), .alarm(alarm), .state_code(state_code)
    );

    // Reference next state from the requirements (00 setup, 01 load, 10 run, 11 fault).
    function automatic logic [1:0] ref_next(logic [1:0] s, logic r, logic l, logic k, logic f);
        if (!r) return 2'b00;                 // R1
        if (l)  return 2'b11;                 // R2
        case (s)
            2'b00: return (!k && f) ? 2'b01 : 2'b00;   // R7
            2'b01: return k ? 2'b10 : 2'b01;           // R5
            2'b10: return f ? 2'b01 : 2'b10;           // R6
            default: return 2'b11;                     // R4
        endcase
    endfunction

    function automatic string ref_tag(logic [1:0] s, logic r, logic l);
        if (!r) return "R1";
        if (l)  return "R2";
        case (s)
            2'b00: return "R7/R8";
            2'b01: return "R5/R8";
            2'b10: return "R6/R8";
            default: return "R4";
        endcase
    endfunction

    // Apply one input set at a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(logic r, logic l, logic k, logic f, string tag);
        rst_n = r; limit_hit = l; key_on = k; fixed_ok = f;
        exp_st = ref_next(exp_st, r, l, k, f);
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (state_code !== exp_st) begin
            n_bad++;
            $display("FAIL %s R9 state_code actual=%b expected=%b", tag, state_code, exp_st);
        end
        n_chk++;
        if (alarm !== (exp_st == 2'b11)) begin
            n_bad++;
            $display("FAIL %s R3 alarm actual=%b expected=%b", tag, alarm, exp_st == 2'b11);
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        @(negedge clk);
        step(0, 1, 1, 1, "R1 reset beats limit");
        step(1, 0, 1, 1, "R7 key blocks start");
        step(1, 0, 0, 0, "R8 setup hold");
        step(1, 0, 0, 1, "R7 start to load");
        step(1, 0, 0, 1, "R5 load waits key");
        step(1, 0, 1, 0, "R5 load to run");
        step(1, 0, 1, 0, "R6 run holds");
        step(1, 0, 0, 1, "R6 run to load");
        step(1, 0, 1, 0, "R5 load to run again");
        step(1, 1, 0, 0, "R2 run trips");
        step(1, 0, 1, 1, "R4 fault ignores key/fixed");
        step(1, 0, 0, 1, "R4 fault ignores start");
        step(0, 0, 0, 0, "R1 reset leaves fault");
        step(1, 1, 0, 1, "R2 setup trips");
        step(0, 0, 0, 0, "R1 reset");
        step(1, 0, 0, 1, "R7 start");
        step(1, 1, 1, 0, "R2 limit beats key");
        step(0, 0, 0, 0, "R1 reset");
        for (int i = 0; i < 3000; i++) begin
            logic r, l, k, f;
            r = ($urandom % 40) != 0;
            l = ($urandom % 8) == 0;
            k = $urandom % 2;
            f = $urandom % 2;
            step(r, l, k, f, ref_tag(exp_st, r, l));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule